// File: doc/BRIEF.md
# I2C Register-Access Slave Port

This block lets a host on a two-wire I2C bus read and write a small bank of byte-wide registers. It samples SCL and SDA with the system clock and detects start and stop conditions. It checks the address byte against its device address, one bit of which comes from a strap pin. The first byte after a write address loads a subaddress pointer. Each following byte is written at that pointer, and the pointer then advances.

To read, the host writes the subaddress, issues a repeated start and sends the read address. The block then shifts out register contents MSB first and advances the pointer on every host ACK. The pointer stops at the top register. The block never stretches the clock. It drives SDA only as an open-drain enable, and it changes that enable only while SCL is low. The register storage sits outside the block and is reached through a parallel port. Read data on that port must be valid in the same cycle as the address.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the SDA pull-down enable and the write strobe are both low, and the block waits for a start condition.
- R2: The address byte matches when its upper seven bits equal the device address, with bit 1 of the byte taken from `addr_sel_i`. With the pin low, 0x40 and 0x41 match; with it high, 0x42 and 0x43 match. On a match the block pulls SDA low for the ninth clock. On a mismatch it leaves SDA released and ignores all later bytes until the next start.
- R3: Bit 0 of the address byte selects the direction: 0 means the host writes and 1 means the host reads.
- R4: A subaddress byte of 0x10 or above is not acknowledged, and the block returns to idle. Later bytes without a new start are not acknowledged.
- R5: In a write, each data byte is acknowledged and written at the current subaddress, and the subaddress then increments.
- R6: A data byte that arrives after register 0x0F has been written is not stored and is not acknowledged. The block returns to idle.
- R7: In a read, bytes come out MSB first starting at the pointer. Each host ACK moves the pointer up by one but not past 0x0F, so register 0x0F repeats. A host NACK ends the read and releases SDA.
- R8: A start or stop seen at any point, including mid-byte, ends the current transfer at once. A stop leads to idle; a start begins a new address byte.
- R9: The SDA pull-down enable rises or falls only while the synchronized SCL is low.
- R10: A stop followed by a start within a single SCL high period is accepted, and the new transfer proceeds normally.
- R11: Each accepted data byte produces a write strobe exactly one system clock long. During that cycle the address and data ports carry the byte and its subaddress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| addr_sel_i | input | 1 | Strap that sets bit 1 of the address byte |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr_o | output | 4 | Register index for read data, or write target while the strobe is high |
| reg_wdata_o | output | 8 | Write data, valid with the strobe |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Register content at `reg_addr_o`, same cycle |

## Verification
The hardest state to reach from the pins is the saturated read. The pointer must already sit at 0x0F, and the host must then keep ACKing. The bench reaches it by first writing 0x0E and 0x0F and then reading from 0x0D over five bytes, so the top register repeats twice before the final NACK. The stop-then-start within one SCL high period is also hard to provoke. A dedicated bus task makes SDA rise and fall again before SCL drops, in the middle of a live write. Mid-byte aborts are driven by cutting a data byte after three or four bits. The bench then shows that no write strobe appears and that no ACK follows.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_SETUP,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_MACK_WAIT
    } slv_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_SUB,
        K_DATA
    } byte_kind_e;

endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_d, scl_q;
    logic sda_d, sda_q;

    always_comb begin
        scl_d = scl_i;
        sda_d = sda_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h20,
    parameter int         REG_COUNT = 16,
    localparam int        PTR_W     = $clog2(REG_COUNT)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [7:0]       rdata_i,
    output logic             sda_oe_o,
    output logic             we_o,
    output logic [7:0]       wdata_o,
    output logic [PTR_W-1:0] ptr_o
);

    localparam logic [PTR_W-1:0] PTR_MAX   = PTR_W'(REG_COUNT - 1);
    localparam logic [8:0]       SUB_LIMIT = 9'(REG_COUNT);

    typedef struct packed {
        slv_state_e       state;
        byte_kind_e       kind;
        logic [2:0]       cnt;
        logic [7:0]       shift;
        logic [PTR_W-1:0] ptr;
        logic             rw;
        logic             wfull;
        logic             oe;
        logic             we;
        logic [7:0]       wdata;
    } fsm_t;

    fsm_t       n_d, q_q;
    logic [7:0] byte_nx;
    logic [6:0] dev_addr;

    assign dev_addr = {DEV_ADDR[6:1], addr_sel_i};
    assign byte_nx  = {q_q.shift[6:0], sda_i};

    always_comb begin
        n_d    = q_q;
        n_d.we = 1'b0;
        if (stop_i) begin
            n_d.state = ST_IDLE;
            n_d.oe    = 1'b0;
        end else if (start_i) begin
            n_d.state = ST_RX;
            n_d.kind  = K_ADDR;
            n_d.cnt   = 3'd0;
            n_d.oe    = 1'b0;
        end else begin
            unique case (q_q.state)
                ST_IDLE: begin
                    n_d.oe = 1'b0;
                end
                ST_RX: begin
                    if (rise_i) begin
                        n_d.shift = byte_nx;
                        n_d.cnt   = q_q.cnt + 3'd1;
                        if (q_q.cnt == 3'd7) begin
                            n_d.state = ST_IDLE;
                            unique case (q_q.kind)
                                K_ADDR: begin
                                    if (byte_nx[7:1] == dev_addr) begin
                                        n_d.rw    = byte_nx[0];
                                        n_d.state = ST_ACK_SETUP;
                                    end
                                end
                                K_SUB: begin
                                    if ({1'b0, byte_nx} < SUB_LIMIT) begin
                                        n_d.ptr   = byte_nx[PTR_W-1:0];
                                        n_d.wfull = 1'b0;
                                        n_d.state = ST_ACK_SETUP;
                                    end
                                end
                                default: begin
                                    if (!q_q.wfull) begin
                                        n_d.we    = 1'b1;
                                        n_d.wdata = byte_nx;
                                        n_d.state = ST_ACK_SETUP;
                                    end
                                end
                            endcase
                        end
                    end
                end
                ST_ACK_SETUP: begin
                    if (fall_i) begin
                        n_d.oe    = 1'b1;
                        n_d.state = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (fall_i) begin
                        n_d.oe  = 1'b0;
                        n_d.cnt = 3'd0;
                        unique case (q_q.kind)
                            K_ADDR: begin
                                if (q_q.rw) begin
                                    n_d.shift = rdata_i;
                                    n_d.oe    = ~rdata_i[7];
                                    n_d.state = ST_TX;
                                end else begin
                                    n_d.kind  = K_SUB;
                                    n_d.state = ST_RX;
                                end
                            end
                            K_SUB: begin
                                n_d.kind  = K_DATA;
                                n_d.state = ST_RX;
                            end
                            default: begin
                                n_d.state = ST_RX;
                                if (q_q.ptr == PTR_MAX) begin
                                    n_d.wfull = 1'b1;
                                end else begin
                                    n_d.ptr = q_q.ptr + 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (fall_i) begin
                        if (q_q.cnt == 3'd7) begin
                            n_d.oe    = 1'b0;
                            n_d.state = ST_MACK;
                        end else begin
                            n_d.shift = {q_q.shift[6:0], 1'b0};
                            n_d.oe    = ~q_q.shift[6];
                            n_d.cnt   = q_q.cnt + 3'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (rise_i) begin
                        if (!sda_i) begin
                            if (q_q.ptr != PTR_MAX) begin
                                n_d.ptr = q_q.ptr + 1'b1;
                            end
                            n_d.state = ST_MACK_WAIT;
                        end else begin
                            n_d.state = ST_IDLE;
                        end
                    end
                end
                ST_MACK_WAIT: begin
                    if (fall_i) begin
                        n_d.shift = rdata_i;
                        n_d.oe    = ~rdata_i[7];
                        n_d.cnt   = 3'd0;
                        n_d.state = ST_TX;
                    end
                end
                default: begin
                    n_d.state = ST_IDLE;
                    n_d.oe    = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q <= '{state: ST_IDLE, kind: K_ADDR, cnt: 3'd0, shift: 8'h00,
                     ptr: '0, rw: 1'b0, wfull: 1'b0, oe: 1'b0, we: 1'b0,
                     wdata: 8'h00};
        end else begin
            q_q <= n_d;
        end
    end

    assign sda_oe_o = q_q.oe;
    assign we_o     = q_q.we;
    assign wdata_o  = q_q.wdata;
    assign ptr_o    = q_q.ptr;

    // R9: the pull-down enable toggles only in the SCL low phase
    a_r9_oe_rise_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q_q.oe) |-> !scl_i);
    a_r9_oe_fall_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(q_q.oe) |-> !scl_i);

    // R11: a write strobe never lasts two cycles
    a_r11_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_q.we |=> !q_q.we);

    // R8: a start restarts the address byte, a stop parks the block
    a_r8_start_new_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (q_q.state == ST_RX && q_q.kind == K_ADDR && q_q.cnt == 3'd0 && !q_q.oe));
    a_r8_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (q_q.state == ST_IDLE && !q_q.oe));

    // R7: the read pointer holds at the top register
    a_r7_ptr_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_q.state == ST_MACK && q_q.ptr == PTR_MAX) |=> q_q.ptr == PTR_MAX);

    // R6: no store once the top register has been written
    a_r6_no_store_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_q.wfull && q_q.kind == K_DATA && q_q.state == ST_RX) |=> !q_q.we);

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h20,
    parameter int         REG_COUNT   = 16,
    parameter int         SYNC_STAGES = 2,
    localparam int        PTR_W       = $clog2(REG_COUNT)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel_i,
    output logic             sda_oe_o,
    output logic [PTR_W-1:0] reg_addr_o,
    output logic [7:0]       reg_wdata_o,
    output logic             reg_we_o,
    input  logic [7:0]       reg_rdata_i
);

    logic [2:0] pins_s;
    logic       scl_s, sda_s, sel_s;
    logic       rise, fall, start, stop;

    i2c_in_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b011)
    ) i_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({addr_sel_i, scl_i, sda_i}),
        .q_o   (pins_s)
    );

    assign sel_s = pins_s[2];
    assign scl_s = pins_s[1];
    assign sda_s = pins_s[0];

    i2c_bus_cond i_cond (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .scl_i     (scl_s),
        .sda_i     (sda_s),
        .scl_rise_o(rise),
        .scl_fall_o(fall),
        .start_o   (start),
        .stop_o    (stop)
    );

    i2c_slv_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .REG_COUNT(REG_COUNT)
    ) i_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .scl_i     (scl_s),
        .sda_i     (sda_s),
        .addr_sel_i(sel_s),
        .rise_i    (rise),
        .fall_i    (fall),
        .start_i   (start),
        .stop_i    (stop),
        .rdata_i   (reg_rdata_i),
        .sda_oe_o  (sda_oe_o),
        .we_o      (reg_we_o),
        .wdata_o   (reg_wdata_o),
        .ptr_o     (reg_addr_o)
    );

    // R1: quiet outputs straight after reset release
    a_r1_quiet_after_reset: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (!sda_oe_o && !reg_we_o));

    // R11: write address stays put while the strobe is high
    a_r11_addr_stable_on_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_we_o |-> $stable(reg_addr_o));

endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_oe;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    wire        sda_line = m_sda & ~sda_oe;

    logic [7:0]  bank [16];
    logic [7:0]  expv [16];
    logic [11:0] wq [$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_reg_slave i_i2c_reg_slave (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .addr_sel_i (addr_sel),
        .sda_oe_o   (sda_oe),
        .reg_addr_o (reg_addr),
        .reg_wdata_o(reg_wdata),
        .reg_we_o   (reg_we),
        .reg_rdata_i(reg_rdata)
    );

    assign reg_rdata = bank[reg_addr];

    always @(posedge clk) begin
        if (reg_we) bank[reg_addr] <= reg_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: each strobe must match the oldest expected write
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (wq.size() == 0) begin
                chk(1'b0, "R5/R6 unexpected write", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [11:0] e;
                e = wq.pop_front();
                chk({reg_addr, reg_wdata} == e, "R5/R11 write strobe", {reg_addr, reg_wdata}, e);
            end
        end
    end

    task automatic exp_write(input logic [3:0] a, input logic [7:0] d);
        wq.push_back({a, d});
        expv[a] = d;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        wait_clk(3);
        m_sda = b;
        wait_clk(HALF);
        scl = 1'b1;
        wait_clk(HALF);
        s = sda_line;
        scl = 1'b0;
    endtask

    task automatic bus_start();
        wait_clk(3);
        m_sda = 1'b1;
        wait_clk(HALF);
        scl = 1'b1;
        wait_clk(HALF);
        m_sda = 1'b0;
        wait_clk(HALF);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(3);
        m_sda = 1'b0;
        wait_clk(HALF);
        scl = 1'b1;
        wait_clk(HALF);
        m_sda = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic bus_stop_start();
        wait_clk(3);
        m_sda = 1'b0;
        wait_clk(HALF);
        scl = 1'b1;
        wait_clk(HALF);
        m_sda = 1'b1;
        wait_clk(HALF);
        m_sda = 1'b0;
        wait_clk(HALF);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic send_bits(input logic [7:0] d, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) clk_bit(d[i], s);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        logic s;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clk_bit(mack ? 1'b0 : 1'b1, s);
    endtask

    initial begin
        wait_clk(150000);
        chk(1'b0, "watchdog", 0, 1);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] d;
        logic s;
        for (int i = 0; i < 16; i++) begin
            bank[i] = 8'hC0 + 8'(i);
            expv[i] = 8'hC0 + 8'(i);
        end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
        chk(reg_we == 1'b0, "R1 we after reset", reg_we, 0);

        // R2: wrong address, then a matching pattern without a start
        bus_start();
        send_byte(8'h44, ack);
        chk(!ack, "R2 mismatch nack", ack, 0);
        send_byte(8'h40, ack);
        chk(!ack, "R2 ignored until start", ack, 0);
        bus_stop();

        // R2/R5: write with pin low
        bus_start();
        send_byte(8'h40, ack);
        chk(ack, "R2 addr 0x40 ack", ack, 1);
        send_byte(8'h02, ack);
        chk(ack, "R5 sub ack", ack, 1);
        exp_write(4'h2, 8'h11);
        send_byte(8'h11, ack);
        chk(ack, "R5 data ack", ack, 1);
        exp_write(4'h3, 8'h22);
        send_byte(8'h22, ack);
        chk(ack, "R5 data ack auto-inc", ack, 1);
        bus_stop();

        // R2/R6: pin high, run off the top
        addr_sel = 1'b1;
        wait_clk(5);
        bus_start();
        send_byte(8'h40, ack);
        chk(!ack, "R2 0x40 rejected with pin high", ack, 0);
        bus_start();
        send_byte(8'h42, ack);
        chk(ack, "R2 addr 0x42 ack", ack, 1);
        send_byte(8'h0E, ack);
        exp_write(4'hE, 8'h33);
        send_byte(8'h33, ack);
        exp_write(4'hF, 8'h44);
        send_byte(8'h44, ack);
        chk(ack, "R5 write top register ack", ack, 1);
        send_byte(8'h55, ack);
        chk(!ack, "R6 past top nack", ack, 0);
        send_byte(8'h66, ack);
        chk(!ack, "R6 idle after overflow", ack, 0);
        bus_stop();

        // R3/R7: read with saturation
        bus_start();
        send_byte(8'h42, ack);
        send_byte(8'h0D, ack);
        bus_start();
        send_byte(8'h43, ack);
        chk(ack, "R3 read addr ack", ack, 1);
        recv_byte(1'b1, d);
        chk(d == expv[13], "R7 read 0x0D", d, expv[13]);
        recv_byte(1'b1, d);
        chk(d == expv[14], "R7 read 0x0E", d, expv[14]);
        recv_byte(1'b1, d);
        chk(d == expv[15], "R7 read 0x0F", d, expv[15]);
        recv_byte(1'b1, d);
        chk(d == expv[15], "R7 saturate once", d, expv[15]);
        recv_byte(1'b0, d);
        chk(d == expv[15], "R7 saturate twice", d, expv[15]);
        clk_bit(1'b1, s);
        chk(s == 1'b1, "R7 released after nack", s, 1);
        bus_stop();

        // R4: invalid subaddress
        bus_start();
        send_byte(8'h42, ack);
        send_byte(8'h10, ack);
        chk(!ack, "R4 sub 0x10 nack", ack, 0);
        send_byte(8'h77, ack);
        chk(!ack, "R4 idle after bad sub", ack, 0);
        bus_stop();

        // R8: stop mid-byte
        bus_start();
        send_byte(8'h42, ack);
        send_byte(8'h05, ack);
        send_bits(8'hF0, 4);
        bus_stop();
        send_byte(8'h42, ack);
        chk(!ack, "R8 idle after mid-byte stop", ack, 0);
        bus_stop();

        // R8: start mid-byte
        bus_start();
        send_byte(8'h42, ack);
        send_byte(8'h06, ack);
        send_bits(8'hA0, 3);
        bus_start();
        send_byte(8'h42, ack);
        chk(ack, "R8 new address after mid-byte start", ack, 1);
        send_byte(8'h07, ack);
        exp_write(4'h7, 8'h99);
        send_byte(8'h99, ack);
        chk(ack, "R8 write after restart", ack, 1);

        // R10: stop then start in one SCL high phase
        bus_start();
        send_byte(8'h42, ack);
        send_byte(8'h09, ack);
        exp_write(4'h9, 8'h5C);
        send_byte(8'h5C, ack);
        bus_stop_start();
        send_byte(8'h42, ack);
        chk(ack, "R10 addr after stop+start", ack, 1);
        send_byte(8'h08, ack);
        exp_write(4'h8, 8'hAB);
        send_byte(8'hAB, ack);
        chk(ack, "R10 data after stop+start", ack, 1);
        bus_stop();

        // read back stored bytes
        bus_start();
        send_byte(8'h42, ack);
        send_byte(8'h02, ack);
        bus_start();
        send_byte(8'h43, ack);
        recv_byte(1'b1, d);
        chk(d == expv[2], "R5 stored 0x02", d, expv[2]);
        recv_byte(1'b0, d);
        chk(d == expv[3], "R5 stored 0x03", d, expv[3]);
        bus_stop();

        bus_start();
        send_byte(8'h42, ack);
        send_byte(8'h07, ack);
        bus_start();
        send_byte(8'h43, ack);
        recv_byte(1'b1, d);
        chk(d == expv[7], "R8 stored 0x07", d, expv[7]);
        recv_byte(1'b1, d);
        chk(d == expv[8], "R10 stored 0x08", d, expv[8]);
        recv_byte(1'b0, d);
        chk(d == expv[9], "R10 stored 0x09", d, expv[9]);
        bus_stop();

        wait_clk(10);
        chk(wq.size() == 0, "R5/R6 all expected writes seen", wq.size(), 0);
        chk(sda_oe == 1'b0, "R8 bus released at end", sda_oe, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule